// File: doc/BRIEF.md
# CPU Interface Running-Priority Tracker

This block is the per-core part of an interrupt controller's CPU interface that keeps track of which preemption priority levels are in service. It holds, for a small set of interrupt IDs, a programmable priority, a pending bit and an active bit. Beside those it keeps an active-priority bit vector with one bit per preemption level. The running priority is read from that vector: the most urgent level that is set, or the idle value 0xFF when no bit is set. The block raises its interrupt request only when the most urgent pending, non-active interrupt is numerically below both the running priority and a priority mask.

The core acknowledges an interrupt and later completes it with an end-of-interrupt that both drops the priority and deactivates the interrupt. Completions follow stack order, so each one drops the most urgent active level. Software can also write the active-priority vector directly. Writing zero is the recovery path when the acknowledged ID has been lost: the running priority returns to idle without touching any interrupt's own pending or active state. A separate clear-active operation from the distributor side deactivates one interrupt and leaves the running priority alone.

Priorities are 8 bits, and a lower value means more urgent. The upper 5 bits select one of 32 preemption levels. The running priority is that level shifted back into 8-bit form, with the lower 3 bits zero.

Top module: `rpt_cpu_if`

## Requirements
- R1: After a synchronous active-low reset, rpr reads 0xFF, irq is 0, eoi_err is 0, ack_id reads 1023, no interrupt is pending or active, and every priority is 0xFF.
- R2: The candidate is the pending, non-active interrupt with the lowest priority value, with ties going to the lower ID. It qualifies when its priority is below both rpr and pmr. ack_id shows the candidate's ID while it qualifies and 1023 otherwise. An honoured acknowledge clears that ID's pending bit and sets its active bit. It also sets vector bit prio[7:3], so rpr equals {prio[7:3],3'b000} in the next cycle.
- R3: rpr is {i,3'b000}, where i is the lowest-numbered set bit of the active-priority vector, or 0xFF when the vector is empty.
- R4: An honoured end-of-interrupt clears the lowest-numbered set bit of the vector and clears the active bit of eoi_id, in one operation.
- R5: irq is 1 exactly when a candidate qualifies. A priority equal to rpr or to pmr does not qualify.
- R6: A write to the active-priority vector loads apr_wdata, with bit i standing for level i. A write of zero returns rpr to 0xFF in the next cycle. Such a write changes no pending or active bit, so an interrupt that is still active stays out of selection.
- R7: A clear-active request clears only the active bit of deact_id. It leaves the vector and rpr unchanged.
- R8: An end-of-interrupt while the vector is empty changes nothing and sets eoi_err, which stays set until reset.
- R9: When operations coincide, the vector write takes precedence, then end-of-interrupt, then acknowledge, and each losing operation has no effect. A pending set on the same ID wins over an acknowledge's pending clear. An acknowledge's active set wins over a clear of the same ID.
- R10: cfg_we writes cfg_prio as the priority of cfg_id, and irq_set bits set pending bits, which stay set until acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_id | input | 10 | Interrupt ID whose priority is written |
| cfg_prio | input | 8 | Priority value to write |
| irq_set | input | 16 | One bit per ID, sets the pending bit |
| pmr | input | 8 | Priority mask |
| ack_req | input | 1 | Acknowledge strobe |
| ack_id | output | 10 | ID an acknowledge takes, or 1023 |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID to deactivate on end-of-interrupt |
| apr_we | input | 1 | Active-priority vector write strobe |
| apr_wdata | input | 32 | Value loaded into the vector |
| deact_req | input | 1 | Clear-active strobe |
| deact_id | input | 10 | ID whose active bit is cleared |
| rpr | output | 8 | Running priority |
| irq | output | 1 | Interrupt request to the core |
| eoi_err | output | 1 | Sticky flag for an end-of-interrupt on an empty vector |

## Verification
Nested acknowledges at 0x80, 0x40 and 0x20 followed by completions in reverse order show whether the vector behaves as a stack. They also show whether equal-priority pending interrupts stay blocked until the running priority falls below them. Sweeping pmr around the candidate's value separates a strict compare from an inclusive one. Clearing the vector while interrupts remain active, and then using the clear-active path, shows that the two kinds of state are kept apart in both directions. Coinciding vector-write, completion and acknowledge strobes exercise the precedence order, and two pending interrupts at equal priority expose the tie-break.

// File: rtl/rpt_pkg.sv
// Package: shared widths and constants for the running-priority tracker.
// Assumes 8-bit priorities where a smaller value is more urgent.
package rpt_pkg;
    localparam int PRIO_W       = 8;
    localparam int PREEMPT_BITS = 5;
    localparam int LEVELS       = 1 << PREEMPT_BITS;
    localparam int SUB_W        = PRIO_W - PREEMPT_BITS;
    localparam int ID_W         = 10;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

    typedef logic [PRIO_W-1:0]       prio_t;
    typedef logic [ID_W-1:0]         id_t;
    typedef logic [PREEMPT_BITS-1:0] level_t;
endpackage

// File: rtl/rpt_irq_state.sv
// Module: rpt_irq_state
// Holds the priority, pending and active bits of each interrupt ID.
// Assumes the caller has already resolved operation precedence: ack_en,
// clr_a_en and clr_b_en arrive only when they are to take effect.
module rpt_irq_state
    import rpt_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  id_t                  cfg_id,
    input  prio_t                cfg_prio,
    input  logic [NUM_IRQ-1:0]   set_pend,
    input  logic                 ack_en,
    input  id_t                  ack_id,
    input  logic                 clr_a_en,
    input  id_t                  clr_a_id,
    input  logic                 clr_b_en,
    input  id_t                  clr_b_id,
    output logic [NUM_IRQ-1:0]   pend,
    output logic [NUM_IRQ-1:0]   act,
    output prio_t [NUM_IRQ-1:0]  prio
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
        logic hit_ack;
        logic hit_clr;

        // Decode which operations address this ID.
        always_comb begin
            hit_ack = ack_en && (ack_id == id_t'(g));
            hit_clr = (clr_a_en && (clr_a_id == id_t'(g))) ||
                      (clr_b_en && (clr_b_id == id_t'(g)));
        end

        // Priority register, written by configuration.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio[g] <= IDLE_PRIO;
            else if (cfg_we && (cfg_id == id_t'(g)))
                prio[g] <= cfg_prio;
        end

        // Pending bit: a set wins over the acknowledge's clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set_pend[g])
                pend[g] <= 1'b1;
            else if (hit_ack)
                pend[g] <= 1'b0;
        end

        // Active bit: an acknowledge's set wins over any clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act[g] <= 1'b0;
            else if (hit_ack)
                act[g] <= 1'b1;
            else if (hit_clr)
                act[g] <= 1'b0;
        end

        // R10
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] && !hit_ack |=> pend[g]);
    end

endmodule

// File: rtl/rpt_pend_select.sv
// Module: rpt_pend_select
// Finds the most urgent interrupt that is pending and not active.
// A tie on priority goes to the lower ID. Purely combinational.
module rpt_pend_select
    import rpt_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic [NUM_IRQ-1:0]   pend,
    input  logic [NUM_IRQ-1:0]   act,
    input  prio_t [NUM_IRQ-1:0]  prio,
    output logic                 cand_valid,
    output id_t                  cand_id,
    output prio_t                cand_prio
);

    // Linear scan with a strict compare, which keeps the lowest ID on a tie.
    always_comb begin
        cand_valid = 1'b0;
        cand_id    = SPURIOUS_ID;
        cand_prio  = IDLE_PRIO;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && !act[i] && (!cand_valid || prio[i] < cand_prio)) begin
                cand_valid = 1'b1;
                cand_id    = id_t'(i);
                cand_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/rpt_active_prio.sv
// Module: rpt_active_prio
// Active-priority bit vector, one bit per preemption level, and the
// running priority derived from it. Assumes the caller grants at most one
// of write, drop and set per cycle, in that order of precedence.
module rpt_active_prio
    import rpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LEVELS-1:0] wr_data,
    input  logic              drop_en,
    input  logic              set_en,
    input  level_t            set_lvl,
    output prio_t             rpr,
    output logic              empty
);

    logic [LEVELS-1:0] vec;
    level_t            top_lvl;

    // Lowest-numbered set bit is the most urgent active level.
    always_comb begin
        top_lvl = '0;
        for (int i = LEVELS - 1; i >= 0; i--)
            if (vec[i]) top_lvl = level_t'(i);
    end

    // Running priority in 8-bit form, or idle when nothing is active.
    always_comb begin
        empty = (vec == '0);
        rpr   = empty ? IDLE_PRIO : {top_lvl, {SUB_W{1'b0}}};
    end

    // Vector update: direct write, stack drop or new activation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec <= '0;
        else if (wr_en)
            vec <= wr_data;
        else if (drop_en)
            vec[top_lvl] <= 1'b0;
        else if (set_en)
            vec[set_lvl] <= 1'b1;
    end

    // R4
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en && !wr_en && !empty |=> $countones(vec) == $countones($past(vec)) - 1);

endmodule

// File: rtl/rpt_cpu_if.sv
// Module: rpt_cpu_if
// Per-core CPU interface priority tracking: the interrupt request,
// acknowledge, combined drop-and-deactivate completion, direct vector
// write and clear-active operation. Assumes IDs 0..NUM_IRQ-1 exist.
// Other IDs address nothing.
module rpt_cpu_if
    import rpt_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [NUM_IRQ-1:0] irq_set,
    input  logic [PRIO_W-1:0]  pmr,
    input  logic               ack_req,
    output logic [ID_W-1:0]    ack_id,
    input  logic               eoi_req,
    input  logic [ID_W-1:0]    eoi_id,
    input  logic               apr_we,
    input  logic [LEVELS-1:0]  apr_wdata,
    input  logic               deact_req,
    input  logic [ID_W-1:0]    deact_id,
    output logic [PRIO_W-1:0]  rpr,
    output logic               irq,
    output logic               eoi_err
);

    logic [NUM_IRQ-1:0]  pend;
    logic [NUM_IRQ-1:0]  act;
    prio_t [NUM_IRQ-1:0] prio;
    logic                cand_valid;
    id_t                 cand_id;
    prio_t               cand_prio;
    logic                qual;
    logic                vec_empty;
    logic                eoi_take;
    logic                eoi_bad;
    logic                ack_take;

    // Qualification of the candidate and the precedence of operations.
    always_comb begin
        qual     = cand_valid && (cand_prio < rpr) && (cand_prio < pmr);
        eoi_take = eoi_req && !apr_we && !vec_empty;
        eoi_bad  = eoi_req && !apr_we && vec_empty;
        ack_take = ack_req && !apr_we && !eoi_req && qual;
        irq      = qual;
        ack_id   = qual ? cand_id : SPURIOUS_ID;
    end

    // Sticky flag for a completion with nothing active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eoi_err <= 1'b0;
        else if (eoi_bad)
            eoi_err <= 1'b1;
    end

    rpt_irq_state #(.NUM_IRQ(NUM_IRQ)) i_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_id   (cfg_id),
        .cfg_prio (cfg_prio),
        .set_pend (irq_set),
        .ack_en   (ack_take),
        .ack_id   (cand_id),
        .clr_a_en (eoi_take),
        .clr_a_id (eoi_id),
        .clr_b_en (deact_req),
        .clr_b_id (deact_id),
        .pend     (pend),
        .act      (act),
        .prio     (prio)
    );

    rpt_pend_select #(.NUM_IRQ(NUM_IRQ)) i_sel (
        .pend       (pend),
        .act        (act),
        .prio       (prio),
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .cand_prio  (cand_prio)
    );

    rpt_active_prio i_apr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (apr_we),
        .wr_data (apr_wdata),
        .drop_en (eoi_take),
        .set_en  (ack_take),
        .set_lvl (cand_prio[PRIO_W-1 -: PREEMPT_BITS]),
        .rpr     (rpr),
        .empty   (vec_empty)
    );

    // R6
    apr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apr_we && apr_wdata == '0 |=> rpr == IDLE_PRIO);

    // R8
    eoi_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |=> eoi_err);

    // R8
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_req && !apr_we && rpr == IDLE_PRIO |=> eoi_err && rpr == IDLE_PRIO);

    // R7
    deact_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deact_req && !apr_we && !eoi_req && !ack_req |=> $stable(rpr));

    // R2
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && !apr_we && !eoi_req && irq |=> rpr < $past(rpr));

endmodule

// File: tb/test_rpt_cpu_if.sv
// Bench for rpt_cpu_if. A behavioural model built from the requirements
// is compared with the outputs once per clock, away from the edges.
module test_rpt_cpu_if;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_id = '0;
    logic [7:0]  cfg_prio = '0;
    logic [N-1:0] irq_set = '0;
    logic [7:0]  pmr = 8'hFF;
    logic        ack_req = 1'b0;
    logic [9:0]  ack_id;
    logic        eoi_req = 1'b0;
    logic [9:0]  eoi_id = '0;
    logic        apr_we = 1'b0;
    logic [31:0] apr_wdata = '0;
    logic        deact_req = 1'b0;
    logic [9:0]  deact_id = '0;
    logic [7:0]  rpr;
    logic        irq;
    logic        eoi_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Model state
    int m_prio[N];
    bit m_pend[N];
    bit m_act[N];
    bit m_lvl[32];
    bit m_err;

    always #5 clk = ~clk;

    rpt_cpu_if #(.NUM_IRQ(N)) i_rpt_cpu_if (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_prio(cfg_prio), .irq_set(irq_set), .pmr(pmr),
        .ack_req(ack_req), .ack_id(ack_id), .eoi_req(eoi_req),
        .eoi_id(eoi_id), .apr_we(apr_we), .apr_wdata(apr_wdata),
        .deact_req(deact_req), .deact_id(deact_id), .rpr(rpr),
        .irq(irq), .eoi_err(eoi_err)
    );

    function automatic int model_rpr();
        for (int i = 0; i < 32; i++)
            if (m_lvl[i]) return i * 8;
        return 255;
    endfunction

    function automatic int model_cand();
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && !m_act[i] && (best < 0 || m_prio[i] < m_prio[best]))
                best = i;
        if (best >= 0 && m_prio[best] < model_rpr() && m_prio[best] < int'(pmr))
            return best;
        return -1;
    endfunction

    task automatic check(string what, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act_v, exp_v);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 255; m_pend[i] = 0; m_act[i] = 0;
        end
        for (int i = 0; i < 32; i++) m_lvl[i] = 0;
        m_err = 0;
    endtask

    task automatic model_update();
        int c;
        int top;
        bit any;
        bit eoi_t;
        bit ack_t;
        if (!rst_n) begin
            model_reset();
            return;
        end
        c = model_cand();
        any = 0; top = 0;
        for (int i = 31; i >= 0; i--) if (m_lvl[i]) begin any = 1; top = i; end
        eoi_t = eoi_req && !apr_we && any;
        ack_t = ack_req && !apr_we && !eoi_req && (c >= 0);
        if (eoi_req && !apr_we && !any) m_err = 1;
        if (apr_we) for (int i = 0; i < 32; i++) m_lvl[i] = apr_wdata[i];
        else if (eoi_t) m_lvl[top] = 0;
        else if (ack_t) m_lvl[m_prio[c] / 8] = 1;
        for (int i = 0; i < N; i++) begin
            bit hit_ack = ack_t && (c == i);
            bit hit_clr = (eoi_t && int'(eoi_id) == i) || (deact_req && int'(deact_id) == i);
            if (irq_set[i]) m_pend[i] = 1;
            else if (hit_ack) m_pend[i] = 0;
            if (hit_ack) m_act[i] = 1;
            else if (hit_clr) m_act[i] = 0;
            if (cfg_we && int'(cfg_id) == i) m_prio[i] = int'(cfg_prio);
        end
    endtask

    // One clock: compare outputs, advance the model at the edge, clear strobes.
    task automatic step();
        int c;
        #1;
        c = model_cand();
        check("rpr", int'(rpr), model_rpr());
        check("irq", int'(irq), (c >= 0) ? 1 : 0);
        check("ack_id", int'(ack_id), (c >= 0) ? c : 1023);
        check("eoi_err", int'(eoi_err), int'(m_err));
        @(posedge clk);
        model_update();
        @(negedge clk);
        cfg_we = 0; irq_set = '0; ack_req = 0; eoi_req = 0;
        apr_we = 0; deact_req = 0;
    endtask

    task automatic cfg(int id, int p);
        cfg_we = 1; cfg_id = 10'(id); cfg_prio = 8'(p); step();
    endtask
    task automatic setp(int id);
        irq_set[id] = 1'b1; step();
    endtask
    task automatic ack();
        ack_req = 1; step();
    endtask
    task automatic eoi(int id);
        eoi_req = 1; eoi_id = 10'(id); step();
    endtask
    task automatic aprw(logic [31:0] v);
        apr_we = 1; apr_wdata = v; step();
    endtask
    task automatic deact(int id);
        deact_req = 1; deact_id = 10'(id); step();
    endtask

    task automatic expect_out(string what, int act_v, int exp_v);
        #1;
        check(what, act_v, exp_v);
    endtask

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        step();
        rst_n = 1;
        step();
        check("R1 rpr idle", int'(rpr), 255);

        // R10: configure priorities
        cur_req = "R10";
        cfg(0, 8'h80); cfg(1, 8'h40); cfg(2, 8'h40); cfg(3, 8'h20); cfg(4, 8'h47);

        // R2 and R5: nesting and preemption
        cur_req = "R5";
        setp(0);
        check("R5 irq for id0", int'(irq), 1);
        cur_req = "R2";
        ack();
        check("R2 rpr after ack id0", int'(rpr), 8'h80);
        setp(1);
        ack();
        check("R2 rpr after ack id1", int'(rpr), 8'h40);
        cur_req = "R5";
        setp(2);
        check("R5 equal priority blocked", int'(irq), 0);
        setp(3);
        cur_req = "R2";
        ack();
        check("R3 rpr 0x20", int'(rpr), 8'h20);

        // R4: stack-order completion
        cur_req = "R4";
        eoi(3);
        check("R4 rpr back to 0x40", int'(rpr), 8'h40);
        eoi(1);
        check("R4 rpr back to 0x80", int'(rpr), 8'h80);
        check("R4 id2 now qualifies", int'(ack_id), 2);

        // R5: mask compare is strict
        cur_req = "R5";
        pmr = 8'h40; step();
        check("R5 pmr equal blocks", int'(irq), 0);
        pmr = 8'h41; step();
        check("R5 pmr above passes", int'(irq), 1);
        pmr = 8'hFF; step();
        cur_req = "R2";
        ack();
        cur_req = "R4";
        eoi(2); eoi(0);
        cur_req = "R3";
        step();
        check("R3 idle after unwind", int'(rpr), 255);

        // R8: completion on an empty vector
        cur_req = "R8";
        eoi(5);
        check("R8 err set", int'(eoi_err), 1);
        step(); step();
        check("R8 err sticky", int'(eoi_err), 1);

        // R6: wipe the vector while interrupts stay active
        cur_req = "R6";
        setp(0); ack(); setp(1); ack();
        aprw(32'h0);
        check("R6 rpr idle after wipe", int'(rpr), 255);
        setp(0);
        check("R6 active id0 not selected", int'(ack_id), 1023);

        // R7: clear-active leaves the running priority
        cur_req = "R7";
        deact(0);
        check("R7 rpr unchanged", int'(rpr), 255);
        check("R7 id0 selectable", int'(ack_id), 0);
        cur_req = "R6";
        aprw(32'h0000_0010);
        check("R6 rpr from written vector", int'(rpr), 8'h20);
        cur_req = "R7";
        deact(1);
        check("R7 rpr stays 0x20", int'(rpr), 8'h20);

        // R9: precedence of coinciding strobes
        cur_req = "R9";
        apr_we = 1; apr_wdata = 32'h0000_0200; eoi_req = 1; eoi_id = 0; step();
        check("R9 write wins over eoi", int'(rpr), 8'h48);
        setp(3);
        ack_req = 1; eoi_req = 1; eoi_id = 3; step();
        check("R9 eoi wins over ack", int'(rpr), 255);
        check("R9 id3 still pending", int'(ack_id), 3);

        // R2: tie on priority goes to the lower ID
        cur_req = "R2";
        ack(); eoi(3);
        setp(2); setp(1);
        check("R2 tie picks id1", int'(ack_id), 1);
        ack();
        check("R2 rpr 0x40", int'(rpr), 8'h40);
        step();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule